// File: doc/BRIEF.md
# Host Data Bus Byte Steering

This block sits between a 16-bit host data bus and an internal byte-addressed register and buffer port. It looks at two active-low lane enables, address bit 0, the read and write strobes and a mode input. From these it picks one of four transfer shapes: a full word, an even byte, an odd byte carried on the low host lane, or an odd byte on the high host lane. It then presents an internal byte address, byte enables and internal write data laid out by lane. Read data coming back from the internal port is moved onto the host lanes the shape calls for.

Because the odd byte can be carried on the low lane, a host with only eight data lines can reach every byte. In disk-compatible mode the block treats address bits 2:0 as a register index. Only the data register is word wide. Every other register is a byte carried on the low host lane. The 16-bit-port indication tells the host whether the addressed location accepts word transfers.

All host inputs are sampled on the block clock and acted on at the following edge. Internal read data is expected to follow the internal address without a clock in between.

Top module: `byte_steer`

## Requirements
- R1: While reset is low and at the first sample after it, int_we and int_rd are 0, int_be is 00, host_lane_oe is 00, host_rdata is 0 and port16_n is 1.
- R2: In card mode (ide_mode=0), when both ce_lo_n and ce_hi_n are low, the transfer is a word. int_be is 11 and int_addr is the host address with bit 0 cleared. Host lane bits 7:0 map to the even byte (internal bits 7:0) and host bits 15:8 map to the odd byte.
- R3: In card mode, ce_lo_n low alone with A0=0 gives an even-byte transfer on host bits 7:0. int_be is 01 and the data sits at internal bits 7:0.
- R4: In card mode, ce_lo_n low alone with A0=1 gives an odd-byte transfer carried on host bits 7:0. int_be is 10, the data sits at internal bits 15:8 and int_addr equals the host address.
- R5: In card mode, ce_hi_n low alone always gives an odd-byte transfer on host bits 15:8. int_be is 10 and int_addr is the host address with bit 0 set.
- R6: With no valid enable combination, no internal access occurs. In either mode this covers both enables high; in disk mode it also covers both enables low. int_be is 00, int_we and int_rd stay 0, and host_lane_oe stays 00.
- R7: Write data and address are taken when the write strobe rises. int_we is a single-cycle pulse in the cycle after that edge, and it is never raised while wr_n is held low.
- R8: On a byte read, the host lane that is not used reads 0 and its bit in host_lane_oe (bit 0 = bits 7:0, bit 1 = bits 15:8) is 0. Unused internal write lanes are 0.
- R9: In disk mode (ide_mode=1), ce_lo_n low alone with address bits 2:0 = 000 selects the data register. This is a word transfer with int_be 11 on both host lanes.
- R10: In disk mode, any other single enable gives a byte transfer on host bits 7:0, with int_be 01 for even and 10 for odd addresses. int_ctl_blk is 1 only when ce_hi_n alone is low.
- R11: port16_n is 0 in card mode whenever either enable is low. In disk mode it is 0 only for the data register. Otherwise it is 1.
- R12: int_addr, int_be, int_rd, int_ctl_blk and port16_n follow the host inputs one clock edge after they are sampled. host_rdata and host_lane_oe follow after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ide_mode | input | 1 | 1 = disk-compatible register mode, 0 = card mode |
| ce_lo_n | input | 1 | Low lane enable, active low |
| ce_hi_n | input | 1 | High lane enable, active low |
| host_addr | input | AW | Host byte address, bit 0 is A0 |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, acted on at its rising edge |
| host_wdata | input | 2*LW | Data from host bus |
| host_rdata | output | 2*LW | Data toward host bus |
| host_lane_oe | output | 2 | Per-lane host bus drive enable |
| port16_n | output | 1 | Low when the addressed location supports word transfers |
| int_addr | output | AW | Internal byte address |
| int_be | output | 2 | Internal byte enables (bit 0 even, bit 1 odd) |
| int_we | output | 1 | Internal write pulse |
| int_rd | output | 1 | Internal read active |
| int_wdata | output | 2*LW | Internal write data by lane |
| int_rdata | input | 2*LW | Internal read data by lane |
| int_ctl_blk | output | 1 | Disk mode access targets the control block |

## Verification
The decode outputs are due one edge after the host inputs are sampled. Returned read data and lane enables are due two edges after. The write pulse comes one edge after the edge that first sees wr_n high. The bench drives inputs on falling edges and checks each result at the falling edge after the rising edge where it is due. It also checks that int_we is still 0 after an edge where wr_n was low, and again one cycle after the pulse. The sweep covers both modes, all four enable combinations and sixteen addresses, with a write followed by a read back through a byte memory model held in the bench.

// File: rtl/bsteer_pkg.sv
// Shared types for the byte steering block.
// Assumes a host bus of exactly two byte lanes.
package bsteer_pkg;

    // Shape of one host transfer
    typedef enum logic [2:0] {
        XK_NONE    = 3'd0,
        XK_EVEN_LO = 3'd1,
        XK_ODD_LO  = 3'd2,
        XK_ODD_HI  = 3'd3,
        XK_WORD    = 3'd4
    } xfer_kind_e;

    // Internal byte enables for a shape
    function automatic logic [1:0] kind_be(input xfer_kind_e k);
        case (k)
            XK_WORD:             return 2'b11;
            XK_EVEN_LO:          return 2'b01;
            XK_ODD_LO, XK_ODD_HI: return 2'b10;
            default:             return 2'b00;
        endcase
    endfunction

    // Host lanes used by a shape
    function automatic logic [1:0] kind_lanes(input xfer_kind_e k);
        case (k)
            XK_WORD:               return 2'b11;
            XK_EVEN_LO, XK_ODD_LO: return 2'b01;
            XK_ODD_HI:             return 2'b10;
            default:               return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/bsteer_decode.sv
// Combinational decode of enables, address and mode into a transfer shape.
// Assumes AW >= 3 so a disk-mode register index fits in bits 2:0.
module bsteer_decode
    import bsteer_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          ide_mode,
    input  logic          ce_lo_n,
    input  logic          ce_hi_n,
    input  logic [AW-1:0] addr,
    output xfer_kind_e    kind,
    output logic [AW-1:0] byte_addr,
    output logic          ctl_blk,
    output logic          wide_port
);

    localparam int IDX_W = 3;

    logic lo_on, hi_on, data_reg;

    assign lo_on    = ~ce_lo_n;
    assign hi_on    = ~ce_hi_n;
    assign data_reg = (addr[IDX_W-1:0] == '0);

    // Pick the transfer shape for the current mode
    always_comb begin
        kind      = XK_NONE;
        ctl_blk   = 1'b0;
        wide_port = 1'b0;
        if (!ide_mode) begin
            wide_port = lo_on | hi_on;
            unique case ({hi_on, lo_on})
                2'b11:   kind = XK_WORD;
                2'b01:   kind = addr[0] ? XK_ODD_LO : XK_EVEN_LO;
                2'b10:   kind = XK_ODD_HI;
                default: kind = XK_NONE;
            endcase
        end else begin
            if (lo_on ^ hi_on) begin
                ctl_blk = hi_on;
                if (lo_on && data_reg) begin
                    kind      = XK_WORD;
                    wide_port = 1'b1;
                end else begin
                    kind = addr[0] ? XK_ODD_LO : XK_EVEN_LO;
                end
            end
        end
    end

    // Form the internal byte address for the shape
    always_comb begin
        unique case (kind)
            XK_WORD:   byte_addr = {addr[AW-1:1], 1'b0};
            XK_ODD_HI: byte_addr = {addr[AW-1:1], 1'b1};
            default:   byte_addr = addr;
        endcase
    end

endmodule

// File: rtl/bsteer_wr.sv
// Write path: detects the rising write strobe and places host data by lane.
// Assumes the strobe is already synchronous to clk.
module bsteer_wr
    import bsteer_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_n,
    input  xfer_kind_e      kind,
    input  logic [2*LW-1:0] host_wdata,
    output logic            int_we,
    output logic [2*LW-1:0] int_wdata
);

    localparam int DW = 2 * LW;

    logic          wr_low_q;
    logic          fire;
    logic [DW-1:0] placed;

    assign fire = wr_n & wr_low_q & (kind != XK_NONE);

    // Move host lanes onto internal lanes, unused lane zero
    always_comb begin
        placed = '0;
        unique case (kind)
            XK_WORD:    placed = host_wdata;
            XK_EVEN_LO: placed[LW-1:0]  = host_wdata[LW-1:0];
            XK_ODD_LO:  placed[DW-1:LW] = host_wdata[LW-1:0];
            XK_ODD_HI:  placed[DW-1:LW] = host_wdata[DW-1:LW];
            default:    placed = '0;
        endcase
    end

    // Remember strobe level and capture data at its trailing edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_low_q  <= 1'b0;
            int_we    <= 1'b0;
            int_wdata <= '0;
        end else begin
            wr_low_q <= ~wr_n;
            int_we   <= fire;
            if (fire) int_wdata <= placed;
        end
    end

endmodule

// File: rtl/bsteer_rd.sv
// Read path: moves internal read lanes onto host lanes and sets lane drive.
// Assumes int_rdata follows the registered internal address in the same cycle.
module bsteer_rd
    import bsteer_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_q,
    input  xfer_kind_e      kind_q,
    input  logic [2*LW-1:0] int_rdata,
    output logic [2*LW-1:0] host_rdata,
    output logic [1:0]      host_lane_oe
);

    localparam int DW = 2 * LW;

    logic [DW-1:0] steered;
    logic [1:0]    lanes;

    assign lanes = kind_lanes(kind_q);

    // Choose the internal byte for each host lane
    always_comb begin
        steered = '0;
        unique case (kind_q)
            XK_WORD:    steered = int_rdata;
            XK_EVEN_LO: steered[LW-1:0]  = int_rdata[LW-1:0];
            XK_ODD_LO:  steered[LW-1:0]  = int_rdata[DW-1:LW];
            XK_ODD_HI:  steered[DW-1:LW] = int_rdata[DW-1:LW];
            default:    steered = '0;
        endcase
    end

    // Register returned data and lane drive per lane
    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                host_rdata[g*LW +: LW] <= '0;
                host_lane_oe[g]        <= 1'b0;
            end else begin
                host_rdata[g*LW +: LW] <= (rd_q && lanes[g]) ? steered[g*LW +: LW] : '0;
                host_lane_oe[g]        <= rd_q & lanes[g];
            end
        end
    end

endmodule

// File: rtl/byte_steer.sv
// Top of the host byte steering block: decode stage, write and read paths.
// Assumes host strobes and enables are synchronous to clk.
module byte_steer
    import bsteer_pkg::*;
#(
    parameter int AW = 11,
    parameter int LW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ide_mode,
    input  logic            ce_lo_n,
    input  logic            ce_hi_n,
    input  logic [AW-1:0]   host_addr,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [2*LW-1:0] host_wdata,
    output logic [2*LW-1:0] host_rdata,
    output logic [1:0]      host_lane_oe,
    output logic            port16_n,
    output logic [AW-1:0]   int_addr,
    output logic [1:0]      int_be,
    output logic            int_we,
    output logic            int_rd,
    output logic [2*LW-1:0] int_wdata,
    input  logic [2*LW-1:0] int_rdata,
    output logic            int_ctl_blk
);

    xfer_kind_e    kind_d, kind_q;
    logic [AW-1:0] addr_d;
    logic          ctl_d, wide_d, rd_q;

    bsteer_decode #(.AW(AW)) u_dec (
        .ide_mode  (ide_mode),
        .ce_lo_n   (ce_lo_n),
        .ce_hi_n   (ce_hi_n),
        .addr      (host_addr),
        .kind      (kind_d),
        .byte_addr (addr_d),
        .ctl_blk   (ctl_d),
        .wide_port (wide_d)
    );

    // Register the decoded access for the internal port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q      <= XK_NONE;
            int_addr    <= '0;
            int_ctl_blk <= 1'b0;
            port16_n    <= 1'b1;
            rd_q        <= 1'b0;
        end else begin
            kind_q      <= kind_d;
            int_addr    <= addr_d;
            int_ctl_blk <= ctl_d;
            port16_n    <= ~wide_d;
            rd_q        <= ~rd_n;
        end
    end

    assign int_be = kind_be(kind_q);
    assign int_rd = rd_q && (kind_q != XK_NONE);

    bsteer_wr #(.LW(LW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n       (wr_n),
        .kind       (kind_d),
        .host_wdata (host_wdata),
        .int_we     (int_we),
        .int_wdata  (int_wdata)
    );

    bsteer_rd #(.LW(LW)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_q         (rd_q),
        .kind_q       (kind_q),
        .int_rdata    (int_rdata),
        .host_rdata   (host_rdata),
        .host_lane_oe (host_lane_oe)
    );

endmodule

// File: rtl/byte_steer_chk.sv
// Property checker for byte_steer, attached by bind below.
// Assumes the same parameters as the instance it observes.
module byte_steer_chk #(
    parameter int AW = 11,
    parameter int LW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ide_mode,
    input logic            ce_lo_n,
    input logic            ce_hi_n,
    input logic [AW-1:0]   host_addr,
    input logic [2*LW-1:0] host_rdata,
    input logic [1:0]      host_lane_oe,
    input logic            port16_n,
    input logic [1:0]      int_be,
    input logic            int_we,
    input logic            int_rd,
    input logic            int_ctl_blk
);

    p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_we |=> !int_we);

    p_we_has_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_we |-> (int_be != 2'b00));

    p_idle_no_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lo_n && ce_hi_n) |=> (int_be == 2'b00 && !int_rd));

    p_drive_needs_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_lane_oe != 2'b00) |-> $past(int_rd));

    p_card_wide_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_mode && !(ce_lo_n && ce_hi_n)) |=> !port16_n);

    p_card_no_ctl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_mode |=> !int_ctl_blk);

    p_disk_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_mode && host_addr[2:0] != 3'b000) |=> ($countones(int_be) <= 1));

    p_low_lane_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_lane_oe == 2'b01) |-> (host_rdata[2*LW-1:LW] == '0));

endmodule

bind byte_steer byte_steer_chk #(.AW(AW), .LW(LW)) u_chk (.*);

// File: tb/tb_byte_steer.sv
// Sweep bench: both modes, all enable pairs, sixteen addresses, write then read.
module tb_byte_steer;

    localparam int AW = 11;
    localparam int LW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ide_mode = 1'b0;
    logic          ce_lo_n = 1'b1, ce_hi_n = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic          rd_n = 1'b1, wr_n = 1'b1;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata, int_wdata, int_rdata;
    logic [1:0]    host_lane_oe, int_be;
    logic          port16_n, int_we, int_rd, int_ctl_blk;
    logic [AW-1:0] int_addr;

    int n_chk = 0, n_fail = 0;
    logic [7:0] bmem [16];
    logic [7:0] emem [16];

    always #5 clk = ~clk;

    byte_steer #(.AW(AW), .LW(LW)) dut (.*);

    // Bench byte memory behind the internal port
    assign int_rdata = {bmem[{int_addr[3:1], 1'b1}], bmem[{int_addr[3:1], 1'b0}]};
    always @(posedge clk) begin
        if (int_we) begin
            if (int_be[0]) bmem[{int_addr[3:1], 1'b0}] <= int_wdata[7:0];
            if (int_be[1]) bmem[{int_addr[3:1], 1'b1}] <= int_wdata[15:8];
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Expected shape from the requirements
    logic [1:0] e_be, e_lanes;
    logic [3:0] e_addr;
    logic       e_p16, e_ctl;
    string      e_req;

    task automatic expect_of(input int m, input int ce, input int a);
        logic lo, hi;
        lo = ~ce[0]; hi = ~ce[1];
        e_be = 0; e_lanes = 0; e_addr = 4'(a); e_p16 = 1; e_ctl = 0; e_req = "R6";
        if (m == 0) begin
            if (lo || hi) e_p16 = 0;
            if (lo && hi) begin e_be = 3; e_lanes = 3; e_addr = 4'(a & 14); e_req = "R2"; end
            else if (lo && a % 2 == 0) begin e_be = 1; e_lanes = 1; e_req = "R3"; end
            else if (lo) begin e_be = 2; e_lanes = 1; e_req = "R4"; end
            else if (hi) begin e_be = 2; e_lanes = 2; e_addr = 4'(a | 1); e_req = "R5"; end
        end else if (lo != hi) begin
            e_ctl = hi;
            if (lo && a % 8 == 0) begin e_be = 3; e_lanes = 3; e_p16 = 0; e_req = "R9"; end
            else begin e_be = (a % 2 == 1) ? 2'd2 : 2'd1; e_lanes = 1; e_req = "R10"; end
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin bmem[i] = 8'h00; emem[i] = 8'h00; end
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(int_we == 0 && int_rd == 0 && int_be == 0, "R1", {int_we, int_rd, int_be}, 0);
        chk(host_lane_oe == 0 && host_rdata == 0 && port16_n == 1, "R1",
            {host_lane_oe, host_rdata, port16_n}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int_be == 0 && port16_n == 1 && host_lane_oe == 0, "R1", {int_be, port16_n}, 1);

        for (int m = 0; m < 2; m++) begin
            for (int ce = 0; ce < 4; ce++) begin
                for (int a = 0; a < 16; a++) begin
                    logic [15:0] d, ew, er;
                    d = 16'(a * 16'h1111) ^ 16'(ce * 16'h0C30) ^ 16'(m * 16'h8001) ^ 16'h5A96;
                    expect_of(m, ce, a);
                    ew = (e_lanes == 3) ? d : (e_lanes == 2) ? {d[15:8], 8'h00} :
                         (e_be == 2) ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
                    // Write: wrong data while strobe low, real data before it rises
                    @(negedge clk);
                    ide_mode = m[0]; ce_lo_n = ce[0]; ce_hi_n = ce[1];
                    host_addr = AW'(a); host_wdata = ~d; wr_n = 0;
                    @(negedge clk);
                    chk(int_we == 0, "R7", int_we, 0);
                    chk(port16_n == e_p16, "R11", port16_n, e_p16);
                    host_wdata = d;
                    @(negedge clk);
                    wr_n = 1;
                    @(negedge clk);
                    chk(int_we == (e_lanes != 0), e_req, int_we, e_lanes != 0);
                    chk(int_be == e_be, e_req, int_be, e_be);
                    chk(int_ctl_blk == e_ctl, "R10", int_ctl_blk, e_ctl);
                    if (e_lanes != 0) begin
                        chk(int_addr == AW'(e_addr), e_req, int_addr, e_addr);
                        chk(int_wdata == ew, "R8", int_wdata, ew);
                        if (e_lanes == 3) begin
                            emem[e_addr & 4'hE] = d[7:0]; emem[e_addr | 4'h1] = d[15:8];
                        end else if (e_lanes == 2) emem[e_addr] = d[15:8];
                        else emem[e_addr] = d[7:0];
                    end
                    @(negedge clk);
                    chk(int_we == 0, "R7", int_we, 0);
                    ce_lo_n = 1; ce_hi_n = 1;
                    // Read back
                    @(negedge clk);
                    ce_lo_n = ce[0]; ce_hi_n = ce[1]; rd_n = 0;
                    er = (e_lanes == 3) ? {emem[e_addr | 4'h1], emem[e_addr & 4'hE]} :
                         (e_lanes == 2) ? {emem[e_addr], 8'h00} :
                         (e_lanes == 1) ? {8'h00, emem[e_addr]} : 16'h0000;
                    @(negedge clk);
                    chk(int_rd == (e_lanes != 0), "R12", int_rd, e_lanes != 0);
                    chk(host_lane_oe == 0, "R12", host_lane_oe, 0);
                    @(negedge clk);
                    chk(host_rdata == er, e_req, host_rdata, er);
                    chk(host_lane_oe == e_lanes, "R8", host_lane_oe, e_lanes);
                    rd_n = 1; ce_lo_n = 1; ce_hi_n = 1;
                    @(negedge clk);
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule